// File: doc/BRIEF.md
# Looping Trace Execution Sequencer

This block sequences a small accelerator that runs one straight-line instruction trace over and over as a loop, on behalf of a host processor. While the sequencer is idle, the host preloads live-in values into a 16-entry internal register file and writes per-step settings into a configuration memory. A start pulse selects one of four traces. The sequencer then walks through that trace's steps. Each step is a bundle of two chained ALU operations. The intermediate value passes directly from the first operation to the second, and only the final result reaches the register file. After the last step, control wraps back to step zero.

Each step goes through a configure phase, an execute phase and a writeback phase, in that order. The length of each phase comes from the step's own entry. Stores made during an iteration are held in a small buffer and written to the memory port only after the iteration completes. A guard step that fails squashes the iteration in progress: the register file returns to its state at the last completed iteration, the buffered stores are dropped, and the block hands control back to the host. An iteration cap ends a loop whose guards never fail. After the run, the host reads live-outs through a combinational read port.

Top module: `trace_seq_top`

## Requirements
- R1: While busy is low, a livein_we pulse writes livein_data into register livein_addr. liveout_data always shows the register selected by liveout_addr, combinationally.
- R2: Every step computes t = op1(rf[ra], rf[rb]) and then r = op2(t, rf[rc]). The op codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left by b[4:0], 6 shift right logical by b[4:0], 7 pass a. Kind 0 (ALU) writes r into rf[rd] at the end of writeback, and no other register changes. Kind 3 does nothing.
- R3: A step lasts (1+cfg_x) configure cycles, then exe_len+1 execute cycles (capped at 5), then (1+wb_x) writeback cycles. Each iteration adds one commit cycle plus one cycle for each buffered store.
- R4: The configuration entry for a step sits at address {trace, step}. The entry is a 30-bit word, packed from MSB to LSB as: last, kind[1:0], op1[2:0], op2[2:0], ra, rb, rc, rd, cfg_x, exe_len[2:0], wb_x. Steps run in order. After a step with last set, or after step 7, the trace wraps to step 0.
- R5: A kind 1 (store) step buffers the address t and the data rf[rc]. Buffered stores leave on mem_we only after the iteration's last step, in program order, one per cycle.
- R6: A kind 2 (guard) step fails when r is zero. On failure, the register file returns to its contents at the last commit (or at start), the iteration's buffered stores are dropped, and the block exits with side_exit high.
- R7: iter_count counts completed iterations from zero at start. When it reaches MAX_ITER (default 32), the block exits with side_exit low.
- R8: On any exit, busy falls and done is high for exactly one cycle, in the first cycle that busy is low.
- R9: While busy is high, start, livein_we and cfg_we have no effect.
- R10: After reset, busy, done, side_exit, mem_we and iter_count are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running a trace |
| trace_sel | input | 2 | Trace to run |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration address {trace, step} |
| cfg_data | input | 30 | Step configuration word |
| livein_we | input | 1 | Live-in write enable |
| livein_addr | input | 4 | Live-in register index |
| livein_data | input | 32 | Live-in value |
| liveout_addr | input | 4 | Live-out register index |
| liveout_data | output | 32 | Live-out value |
| mem_we | output | 1 | Store write strobe |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| busy | output | 1 | Trace running |
| done | output | 1 | One-cycle exit pulse |
| side_exit | output | 1 | Last exit came from a failed guard |
| iter_count | output | 6 | Completed iterations |

## Verification
The bench runs five traces, each aimed at a different fault.

- A counting loop with a store and a guard that fails on its fifth pass. It tells a correct checkpoint restore and store discard apart from leaking the squashed write or the squashed store.
- A single bundled step that accumulates through an add followed by an xor for the full iteration cap. It separates correct operand chaining and writeback targeting from swapped operations or stray writes.
- Two one-step traces, one with minimum and one with maximum phase lengths. Their total busy cycles expose any error in phase counting.
- An eight-step trace with no last flag. It shows whether the forced wrap after step 7 happens.
- Writes and a start issued during a run, which show whether they are ignored.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
    localparam int DATA_W    = 32;
    localparam int NREG      = 16;
    localparam int REG_AW    = $clog2(NREG);
    localparam int MAX_STEPS = 8;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int NTRACE    = 4;
    localparam int TRACE_W   = $clog2(NTRACE);
    localparam int CRAM_AW   = TRACE_W + STEP_W;
    localparam int CRAM_DEPTH = NTRACE * MAX_STEPS;
    localparam int SB_DEPTH  = MAX_STEPS;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_PASSA
    } alu_op_e;

    typedef enum logic [1:0] {
        K_ALU, K_STORE, K_GUARD, K_NOP
    } step_kind_e;

    typedef struct packed {
        logic              last;
        step_kind_e        kind;
        alu_op_e           op1;
        alu_op_e           op2;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rc;
        logic [REG_AW-1:0] rd;
        logic              cfg_x;
        logic [2:0]        exe_len;
        logic              wb_x;
    } step_cfg_t;

    localparam int CFG_W = $bits(step_cfg_t);

    typedef enum logic [2:0] {
        S_IDLE, S_CFG, S_EXE, S_WB, S_DRAIN
    } seq_state_e;

    function automatic logic [DATA_W-1:0] alu_eval(alu_op_e op,
                                                  logic [DATA_W-1:0] a,
                                                  logic [DATA_W-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_SHL:  return a << b[4:0];
            OP_SHR:  return a >> b[4:0];
            default: return a;
        endcase
    endfunction

    function automatic logic [2:0] exe_cycles(logic [2:0] len);
        return (len > 3'd4) ? 3'd5 : len + 3'd1;
    endfunction
endpackage

// File: rtl/trace_cfg_ram.sv
module trace_cfg_ram #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 30,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trace_regfile.sv
module trace_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [DW-1:0] host_wdata,
    input  logic          wb_we,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic          ckpt_take,
    input  logic          restore,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic [AW-1:0] rc_addr,
    input  logic [AW-1:0] rh_addr,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data,
    output logic [DW-1:0] rc_data,
    output logic [DW-1:0] rh_data
);
    logic [DW-1:0] rf   [NREG];
    logic [DW-1:0] ckpt [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                rf[i]   <= '0;
                ckpt[i] <= '0;
            end
        end else begin
            if (restore) begin
                for (int i = 0; i < NREG; i++) rf[i] <= ckpt[i];
            end else begin
                if (host_we) rf[host_waddr] <= host_wdata;
                if (wb_we)   rf[wb_addr]    <= wb_data;
            end
            if (ckpt_take) begin
                for (int i = 0; i < NREG; i++) ckpt[i] <= rf[i];
            end
        end
    end

    assign ra_data = rf[ra_addr];
    assign rb_data = rf[rb_addr];
    assign rc_data = rf[rc_addr];
    assign rh_data = rf[rh_addr];

    // R6
    restore_excl_chk: assert property (@(posedge clk) disable iff (rst)
        restore |-> !wb_we && !host_we);
endmodule

// File: rtl/trace_store_buf.sv
module trace_store_buf #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          head_valid,
    output logic [DW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full
);
    logic [DW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [AW:0]   wr_cnt;
    logic [AW:0]   rd_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (push && !full) begin
                addr_q[wr_cnt[AW-1:0]] <= push_addr;
                data_q[wr_cnt[AW-1:0]] <= push_data;
                wr_cnt <= wr_cnt + 1'b1;
            end
            if (pop && head_valid) rd_cnt <= rd_cnt + 1'b1;
        end
    end

    assign full       = (wr_cnt == (AW+1)'(DEPTH));
    assign head_valid = (rd_cnt < wr_cnt);
    assign head_addr  = addr_q[rd_cnt[AW-1:0]];
    assign head_data  = data_q[rd_cnt[AW-1:0]];

    // R5
    sb_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R5
    sb_pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);
endmodule

// File: rtl/trace_bundle_alu.sv
module trace_bundle_alu
    import trace_seq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e       op1,
    input  alu_op_e       op2,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] c,
    output logic [DW-1:0] t,
    output logic [DW-1:0] r
);
    assign t = alu_eval(op1, a, b);
    assign r = alu_eval(op2, t, c);
endmodule

// File: rtl/trace_seq_top.sv
module trace_seq_top
    import trace_seq_pkg::*;
#(
    parameter int MAX_ITER = 32,
    localparam int ITER_W  = $clog2(MAX_ITER + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [TRACE_W-1:0]  trace_sel,
    input  logic                cfg_we,
    input  logic [CRAM_AW-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                livein_we,
    input  logic [REG_AW-1:0]   livein_addr,
    input  logic [DATA_W-1:0]   livein_data,
    input  logic [REG_AW-1:0]   liveout_addr,
    output logic [DATA_W-1:0]   liveout_data,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done,
    output logic                side_exit,
    output logic [ITER_W-1:0]   iter_count
);
    localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MAX_STEPS - 1);

    seq_state_e          state;
    logic [STEP_W-1:0]   step;
    logic [TRACE_W-1:0]  trace_q;
    logic [2:0]          ph;
    step_cfg_t           cur_q;
    step_cfg_t           ram_cfg;
    logic [CFG_W-1:0]    ram_word;
    logic [DATA_W-1:0]   res_q, t_q, c_q;
    logic [ITER_W-1:0]   iter_q;
    logic                done_q, exit_q;

    logic [DATA_W-1:0]   a_val, b_val, c_val, t_val, r_val;
    logic                sb_valid, sb_full;
    logic [DATA_W-1:0]   sb_addr, sb_data;

    logic start_acc, wb_last, exe_last, guard_fail, step_end, trace_end;
    logic commit, limit_hit, wb_we, sb_push, ckpt_take;

    trace_cfg_ram #(.DEPTH(CRAM_DEPTH), .WIDTH(CFG_W)) cram_i (
        .clk   (clk),
        .we    (cfg_we && !busy),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr ({trace_q, step}),
        .rdata (ram_word)
    );
    assign ram_cfg = step_cfg_t'(ram_word);

    trace_regfile #(.NREG(NREG), .DW(DATA_W)) rf_i (
        .clk        (clk),
        .rst        (rst),
        .host_we    (livein_we && !busy),
        .host_waddr (livein_addr),
        .host_wdata (livein_data),
        .wb_we      (wb_we),
        .wb_addr    (cur_q.rd),
        .wb_data    (res_q),
        .ckpt_take  (ckpt_take),
        .restore    (guard_fail),
        .ra_addr    (cur_q.ra),
        .rb_addr    (cur_q.rb),
        .rc_addr    (cur_q.rc),
        .rh_addr    (liveout_addr),
        .ra_data    (a_val),
        .rb_data    (b_val),
        .rc_data    (c_val),
        .rh_data    (liveout_data)
    );

    trace_bundle_alu #(.DW(DATA_W)) alu_i (
        .op1 (cur_q.op1),
        .op2 (cur_q.op2),
        .a   (a_val),
        .b   (b_val),
        .c   (c_val),
        .t   (t_val),
        .r   (r_val)
    );

    trace_store_buf #(.DEPTH(SB_DEPTH), .DW(DATA_W)) sb_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (guard_fail || commit),
        .push       (sb_push),
        .push_addr  (t_q),
        .push_data  (c_q),
        .pop        (mem_we),
        .head_valid (sb_valid),
        .head_addr  (sb_addr),
        .head_data  (sb_data),
        .full       (sb_full)
    );

    always_comb begin
        start_acc  = (state == S_IDLE) && start;
        exe_last   = (state == S_EXE) && (ph == exe_cycles(cur_q.exe_len) - 3'd1);
        wb_last    = (state == S_WB) && ((ph == 3'd0 && !cur_q.wb_x) || ph == 3'd1);
        guard_fail = wb_last && (cur_q.kind == K_GUARD) && (res_q == '0);
        wb_we      = wb_last && (cur_q.kind == K_ALU);
        sb_push    = wb_last && (cur_q.kind == K_STORE);
        step_end   = wb_last && !guard_fail;
        trace_end  = step_end && (cur_q.last || step == STEP_LAST);
        mem_we     = (state == S_DRAIN) && sb_valid;
        commit     = (state == S_DRAIN) && !sb_valid;
        limit_hit  = commit && (iter_q == ITER_LAST);
        ckpt_take  = start_acc || commit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            step    <= '0;
            trace_q <= '0;
            ph      <= '0;
            cur_q   <= '0;
            res_q   <= '0;
            t_q     <= '0;
            c_q     <= '0;
            iter_q  <= '0;
            done_q  <= 1'b0;
            exit_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    trace_q <= trace_sel;
                    step    <= '0;
                    ph      <= '0;
                    iter_q  <= '0;
                    exit_q  <= 1'b0;
                    state   <= S_CFG;
                end
                S_CFG: begin
                    if (ph == 3'd0) cur_q <= ram_cfg;
                    if (ph == 3'd0 && ram_cfg.cfg_x) begin
                        ph <= 3'd1;
                    end else begin
                        ph    <= '0;
                        state <= S_EXE;
                    end
                end
                S_EXE: begin
                    if (exe_last) begin
                        res_q <= r_val;
                        t_q   <= t_val;
                        c_q   <= c_val;
                        ph    <= '0;
                        state <= S_WB;
                    end else begin
                        ph <= ph + 3'd1;
                    end
                end
                S_WB: begin
                    if (guard_fail) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        exit_q <= 1'b1;
                    end else if (trace_end) begin
                        state <= S_DRAIN;
                    end else if (step_end) begin
                        step  <= step + 1'b1;
                        ph    <= '0;
                        state <= S_CFG;
                    end else begin
                        ph <= ph + 3'd1;
                    end
                end
                S_DRAIN: if (commit) begin
                    iter_q <= iter_q + 1'b1;
                    step   <= '0;
                    ph     <= '0;
                    if (limit_hit) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= S_CFG;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state != S_IDLE);
    assign done       = done_q;
    assign side_exit  = exit_q;
    assign iter_count = iter_q;
    assign mem_addr   = sb_addr;
    assign mem_wdata  = sb_data;

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    iter_cap_chk: assert property (@(posedge clk) disable iff (rst)
        iter_count <= ITER_W'(MAX_ITER));
    // R3
    exe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXE) |-> (ph < 3'd5));
    // R9
    trace_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(trace_q));
    // R5
    drain_only_chk: assert property (@(posedge clk) disable iff (rst)
        sb_push |-> !mem_we && !sb_full);
endmodule

// File: tb/trace_seq_top_tb_top.sv
module trace_seq_top_tb_top;
    import trace_seq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [TRACE_W-1:0] trace_sel = '0;
    logic cfg_we = 1'b0;
    logic [CRAM_AW-1:0] cfg_addr = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic livein_we = 1'b0;
    logic [REG_AW-1:0] livein_addr = '0;
    logic [DATA_W-1:0] livein_data = '0;
    logic [REG_AW-1:0] liveout_addr = '0;
    logic [DATA_W-1:0] liveout_data;
    logic mem_we;
    logic [DATA_W-1:0] mem_addr, mem_wdata;
    logic busy, done, side_exit;
    logic [5:0] iter_count;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] log_a [64];
    logic [31:0] log_d [64];
    int log_n = 0;

    always #4 clk = ~clk;

    trace_seq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .trace_sel(trace_sel),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .livein_we(livein_we), .livein_addr(livein_addr), .livein_data(livein_data),
        .liveout_addr(liveout_addr), .liveout_data(liveout_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .side_exit(side_exit), .iter_count(iter_count)
    );

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (log_n < 64) begin
                log_a[log_n] = mem_addr;
                log_d[log_n] = mem_wdata;
            end
            log_n = log_n + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic step_cfg_t mk(logic last, step_kind_e k, alu_op_e o1, alu_op_e o2,
                                     int ra, int rb, int rc, int rd,
                                     logic cx, int el, logic wx);
        step_cfg_t s;
        s.last = last; s.kind = k; s.op1 = o1; s.op2 = o2;
        s.ra = 4'(ra); s.rb = 4'(rb); s.rc = 4'(rc); s.rd = 4'(rd);
        s.cfg_x = cx; s.exe_len = 3'(el); s.wb_x = wx;
        return s;
    endfunction

    task automatic put_step(int tr, int st, step_cfg_t s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'({2'(tr), 3'(st)}); cfg_data = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_reg(int r, logic [31:0] v);
        @(negedge clk);
        livein_we = 1'b1; livein_addr = 4'(r); livein_data = v;
        @(negedge clk);
        livein_we = 1'b0;
    endtask

    task automatic get_reg(int r, output logic [31:0] v);
        liveout_addr = 4'(r);
        #1;
        v = liveout_data;
    endtask

    task automatic run(int tr, bit poke, output int cyc);
        int guard_cnt;
        cyc = 0;
        guard_cnt = 0;
        @(negedge clk);
        start = 1'b1; trace_sel = 2'(tr);
        @(negedge clk);
        start = 1'b0;
        if (busy) cyc++;
        forever begin
            if (poke && cyc == 3) begin
                livein_we = 1'b1; livein_addr = 4'd9; livein_data = 32'hDEAD0000;
                cfg_we = 1'b1; cfg_addr = 5'({2'(tr), 3'd0});
                cfg_data = mk(1'b1, K_ALU, OP_ADD, OP_PASSA, 0, 0, 0, 9, 1'b0, 0, 1'b0);
                start = 1'b1; trace_sel = 2'(tr ^ 1);
            end
            @(negedge clk);
            livein_we = 1'b0; cfg_we = 1'b0; start = 1'b0;
            if (busy) cyc++;
            if (done) break;
            guard_cnt++;
            if (guard_cnt > 5000) break;
        end
        check("R8 done with busy low", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check("R8 done one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 busy", {31'b0, busy}, 0);
        check("R10 done", {31'b0, done}, 0);
        check("R10 side_exit", {31'b0, side_exit}, 0);
        check("R10 mem_we", {31'b0, mem_we}, 0);
        check("R10 iter_count", {26'b0, iter_count}, 0);
        get_reg(7, v);
        check("R10 reg clear", v, 0);
    endtask

    task automatic t_livein();
        logic [31:0] v;
        set_reg(14, 32'hCAFEF00D);
        get_reg(14, v);
        check("R1 live-in readback", v, 32'hCAFEF00D);
        get_reg(13, v);
        check("R1 other reg untouched", v, 0);
    endtask

    task automatic t_guard();
        logic [31:0] v;
        int cyc, base;
        put_step(0, 0, mk(1'b0, K_ALU, OP_ADD, OP_PASSA, 1, 2, 0, 1, 1'b0, 0, 1'b0));
        put_step(0, 1, mk(1'b0, K_STORE, OP_ADD, OP_PASSA, 1, 0, 1, 15, 1'b0, 0, 1'b0));
        put_step(0, 2, mk(1'b1, K_GUARD, OP_XOR, OP_PASSA, 1, 4, 0, 15, 1'b0, 0, 1'b0));
        set_reg(0, 0); set_reg(1, 0); set_reg(2, 3); set_reg(4, 15); set_reg(15, 32'h5);
        base = log_n;
        run(0, 0, cyc);
        check("R6 side_exit on guard", {31'b0, side_exit}, 1);
        check("R7 iterations before squash", {26'b0, iter_count}, 4);
        get_reg(1, v);
        check("R6 r1 restored to last commit", v, 12);
        get_reg(15, v);
        check("R2 store step writes no register", v, 5);
        check("R6 squashed store dropped", 32'(log_n - base), 4);
        for (int i = 0; i < 4; i++) begin
            check("R5 store address order", log_a[base+i], 32'(3*(i+1)));
            check("R5 store data order", log_d[base+i], 32'(3*(i+1)));
        end
    endtask

    task automatic t_bundle();
        logic [31:0] v, exp5;
        int cyc;
        put_step(1, 0, mk(1'b1, K_ALU, OP_ADD, OP_XOR, 5, 1, 2, 5, 1'b0, 2, 1'b0));
        set_reg(5, 32'h10); set_reg(1, 32'h01234567); set_reg(2, 32'hA5A5A5A5); set_reg(6, 32'h77);
        exp5 = 32'h10;
        for (int i = 0; i < 32; i++) exp5 = (exp5 + 32'h01234567) ^ 32'hA5A5A5A5;
        run(1, 0, cyc);
        check("R7 limit exit not side exit", {31'b0, side_exit}, 0);
        check("R7 iteration limit", {26'b0, iter_count}, 32);
        get_reg(5, v);
        check("R2 chained add-xor result", v, exp5);
        get_reg(6, v);
        check("R2 unrelated reg unchanged", v, 32'h77);
        get_reg(1, v);
        check("R2 source reg unchanged", v, 32'h01234567);
        check("R3 bundle cycles", 32'(cyc), 32*(1+3+1+1));
    endtask

    task automatic t_timing();
        logic [31:0] v;
        int cyc;
        put_step(2, 0, mk(1'b1, K_ALU, OP_ADD, OP_PASSA, 8, 8, 0, 8, 1'b0, 0, 1'b0));
        put_step(3, 0, mk(1'b1, K_ALU, OP_SHL, OP_OR, 10, 11, 10, 10, 1'b1, 4, 1'b1));
        set_reg(8, 1); set_reg(10, 1); set_reg(11, 0); set_reg(9, 32'h55);
        run(2, 0, cyc);
        check("R3 minimum phases", 32'(cyc), 32*4);
        get_reg(8, v);
        check("R4 trace 2 selected", v, 32'h1 << 32);
        run(3, 1, cyc);
        check("R3 maximum phases", 32'(cyc), 32*10);
        get_reg(9, v);
        check("R9 live-in ignored while busy", v, 32'h55);
        check("R9 start ignored while busy", {26'b0, iter_count}, 32);
        run(3, 0, cyc);
        check("R9 cfg write ignored while busy", 32'(cyc), 32*10);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int cyc;
        for (int s = 0; s < 8; s++)
            put_step(0, s, mk(1'b0, K_ALU, OP_ADD, OP_PASSA, 1, 2, 0, 1, 1'b0, 0, 1'b0));
        set_reg(1, 0); set_reg(2, 1);
        run(0, 0, cyc);
        get_reg(1, v);
        check("R4 eight steps then wrap", v, 256);
        check("R4 wrap cycles", 32'(cyc), 32*25);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_livein();
        t_guard();
        t_bundle();
        t_timing();
        t_wrap();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule